// File: doc/BRIEF.md
# Leveled Prioritized Interrupt Controller

This block gathers the interrupt request lines of up to 63 peripherals and ranks them on seven interrupt levels. Each level holds eight programmable priority slots plus one fixed mid-point slot. The block chooses the most urgent forwardable request and presents its level, registered, to the processor core. Sources 1 to 7 are wired: each sits on the level equal to its own number, in the mid-point slot. Sources 8 to 63 take their level and priority from control registers, which are loaded through a one-cycle write port. Every source also has a mask bit, and each mask bit is set at reset.

When the core runs an interrupt-acknowledge cycle for a level, the controller answers the cycle without involving the peripheral. It returns the vector number of the best pending source on that level, or a spurious vector when there is none, and echoes the acknowledged level so the core can raise its mask. The acknowledge never clears a request. Software has to remove the request at the peripheral itself.

Top module: `lpic_top`

## Requirements
- R1: After reset every source mask bit is 1 (masked), `irq_level` is 0 and `ack_done` is 0, so requests have no effect until a source is unmasked.
- R2: Source n for n in 1..7 is fixed at level n in the mid-point slot, and control-register writes to addresses 0..7 are ignored. Source 0 does not exist and never requests.
- R3: A write with `wr_en`=1, `wr_mask`=0 and `wr_addr` in 8..63 loads level=`wr_data[5:3]` and priority=`wr_data[2:0]`. A write with `wr_mask`=1 loads mask bit `wr_addr` with `wr_data[0]` (1 = masked). A source on level 0 never requests, and `iack_level`=0 always receives the spurious vector.
- R4: The arbiter ranks by level first. Within a level the order is priority 7, 6, 5, 4, then the mid-point slot, then priority 3, 2, 1, 0.
- R5: When enabled sources share the same level and slot, the lowest source number wins.
- R6: A pending unmasked request is forwarded to `irq_level` only if its level is greater than `cpu_mask`, or its level is 7. Level 7 is forwarded even when `cpu_mask` is 7.
- R7: `irq_level` is registered. It shows the level of the winning forwarded request one clock after the inputs change, and 0 when no request is forwarded.
- R8: One clock after `iack_valid`, `ack_done` pulses for one cycle. `ack_vector` is 64 plus the number of the best unmasked pending source on `iack_level`, chosen without regard to `cpu_mask`. `ack_level` equals `iack_level`.
- R9: If no unmasked request is pending on the acknowledged level, `ack_vector` is 24 (spurious).
- R10: An acknowledge leaves requests untouched. Repeating the acknowledge returns the same vector, and `irq_level` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Request line per source; bit 0 is unused |
| cpu_mask | input | 3 | Current interrupt mask of the core |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 1 | 1: write a mask bit, 0: write a level/priority register |
| wr_addr | input | 6 | Source number addressed by the write |
| wr_data | input | 6 | Level in [5:3], priority in [2:0], mask bit in [0] |
| iack_valid | input | 1 | Interrupt-acknowledge cycle strobe |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Registered level of the winning forwarded request |
| ack_done | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Vector number returned for the acknowledge |
| ack_level | output | 3 | Level that was acknowledged |

## Verification
The hardest case to reach is a single level that holds several live requests at once: a wired mid-point source, programmed sources above and below it, and two sources with the same setting. Acknowledges for that level must then return each winner in turn. The stimulus builds this crowd on level 3 and level 2. It then withdraws requests one at a time and reprograms one priority across the mid-point, acknowledging after each change. The bench keeps its own register model, in which the mid-point is expressed as a half step between priorities, to predict every vector.

// File: rtl/lpic_pkg.sv
package lpic_pkg;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int SLOT_W = PRI_W + 1;
  localparam int RANK_W = LVL_W + SLOT_W;
  localparam int CFG_W  = LVL_W + PRI_W;
  localparam int VEC_W  = 8;
  localparam logic [LVL_W-1:0] TOP_LVL = '1;
  localparam logic [PRI_W-1:0] MID_AFTER = 3'd4;

  // Map a programmed priority onto the slot scale, leaving room for the mid-point.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [PRI_W-1:0] p);
    logic [SLOT_W-1:0] s;
    s = {1'b0, p};
    if (p >= MID_AFTER) s = s + 1'b1;
    return s;
  endfunction

  function automatic logic [SLOT_W-1:0] mid_slot();
    return {1'b0, MID_AFTER};
  endfunction

  function automatic logic [RANK_W-1:0] rank_of(input logic [LVL_W-1:0] l,
                                                input logic [SLOT_W-1:0] s);
    return {l, s};
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input int unsigned base,
                                              input int unsigned idx);
    return VEC_W'(base + idx);
  endfunction
endpackage

// File: rtl/lpic_cfg_bank.sv
module lpic_cfg_bank
  import lpic_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int NFIXED = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_mask,
  input  logic [IDX_W-1:0]              wr_addr,
  input  logic [CFG_W-1:0]              wr_data,
  output logic [NSRC-1:0][LVL_W-1:0]    src_lvl,
  output logic [NSRC-1:0][SLOT_W-1:0]   src_slot,
  output logic [NSRC-1:0]               src_msk
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hit;
    assign hit = wr_en && (wr_addr == IDX_W'(i));

    if (i == 0) begin : g_none
      assign src_lvl[i]  = '0;
      assign src_slot[i] = '0;
      assign src_msk[i]  = 1'b1;
    end else begin : g_real
      logic msk_q;
      always_ff @(posedge clk) begin
        if (!rst_n)              msk_q <= 1'b1;
        else if (hit && wr_mask) msk_q <= wr_data[0];
      end
      assign src_msk[i] = msk_q;

      // R3: a mask write lands in the addressed bit on the next clock
      a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_mask) |=> (src_msk[i] == $past(wr_data[0])));

      if (i < NFIXED) begin : g_fixed
        assign src_lvl[i]  = LVL_W'(i);
        assign src_slot[i] = mid_slot();
      end else begin : g_prog
        logic [LVL_W-1:0] lvl_q;
        logic [PRI_W-1:0] pri_q;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            lvl_q <= '0;
            pri_q <= '0;
          end else if (hit && !wr_mask) begin
            lvl_q <= wr_data[CFG_W-1:PRI_W];
            pri_q <= wr_data[PRI_W-1:0];
          end
        end
        assign src_lvl[i]  = lvl_q;
        assign src_slot[i] = slot_of(pri_q);
      end
    end
  end
endmodule

// File: rtl/lpic_arbiter.sv
module lpic_arbiter
  import lpic_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             elig,
  input  logic [NSRC-1:0][RANK_W-1:0] rank,
  output logic                        win_valid,
  output logic [IDX_W-1:0]            win_idx,
  output logic [RANK_W-1:0]           win_rank
);
  // Ascending scan with strict comparison: equal ranks keep the lower index.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_rank  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!win_valid || rank[i] > win_rank)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_rank  = rank[i];
      end
    end
  end

  // R5: the reported winner is one of the requesters
  a_r5_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_idx]);
  // R4: no requester exists when the arbiter reports none
  a_r4_valid_iff_any: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (|elig));
endmodule

// File: rtl/lpic_ack_unit.sv
module lpic_ack_unit
  import lpic_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  input  logic              hit_valid,
  input  logic [IDX_W-1:0]  hit_idx,
  output logic              ack_done,
  output logic [VEC_W-1:0]  ack_vector,
  output logic [LVL_W-1:0]  ack_level
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_done   <= 1'b0;
      ack_vector <= '0;
      ack_level  <= '0;
    end else begin
      ack_done <= iack_valid;
      if (iack_valid) begin
        ack_level  <= iack_level;
        ack_vector <= hit_valid ? vec_of(VEC_BASE, hit_idx) : VEC_W'(VEC_SPUR);
      end
    end
  end

  // R8: every acknowledge is answered in the following cycle
  a_r8_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    iack_valid |=> (ack_done && ack_level == $past(iack_level)));
  // R9: a returned vector is either spurious or inside the source window
  a_r9_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |-> (ack_vector == VEC_W'(VEC_SPUR) ||
                  (ack_vector >= VEC_W'(VEC_BASE) && ack_vector < VEC_W'(VEC_BASE + NSRC))));
endmodule

// File: rtl/lpic_top.sv
module lpic_top
  import lpic_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int NFIXED   = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              wr_en,
  input  logic              wr_mask,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  output logic [LVL_W-1:0]  irq_level,
  output logic              ack_done,
  output logic [VEC_W-1:0]  ack_vector,
  output logic [LVL_W-1:0]  ack_level
);
  logic [NSRC-1:0][LVL_W-1:0]  src_lvl;
  logic [NSRC-1:0][SLOT_W-1:0] src_slot;
  logic [NSRC-1:0]             src_msk;
  logic [NSRC-1:0][RANK_W-1:0] src_rank;
  logic [NSRC-1:0]             live;
  logic [NSRC-1:0]             fwd_elig;
  logic [NSRC-1:0]             ack_elig;

  lpic_cfg_bank #(.NSRC(NSRC), .NFIXED(NFIXED)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .src_lvl(src_lvl), .src_slot(src_slot), .src_msk(src_msk)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign src_rank[i] = rank_of(src_lvl[i], src_slot[i]);
    assign live[i]     = irq_req[i] && !src_msk[i] && (src_lvl[i] != '0);
    assign fwd_elig[i] = live[i] && ((src_lvl[i] > cpu_mask) || (src_lvl[i] == TOP_LVL));
    assign ack_elig[i] = live[i] && (src_lvl[i] == iack_level);
  end

  logic                fwd_valid;
  logic [IDX_W-1:0]    fwd_idx;
  logic [RANK_W-1:0]   fwd_rank;
  logic                hit_valid;
  logic [IDX_W-1:0]    hit_idx;
  logic [RANK_W-1:0]   hit_rank;

  lpic_arbiter #(.NSRC(NSRC)) u_fwd_arb (
    .clk(clk), .rst_n(rst_n), .elig(fwd_elig), .rank(src_rank),
    .win_valid(fwd_valid), .win_idx(fwd_idx), .win_rank(fwd_rank)
  );

  lpic_arbiter #(.NSRC(NSRC)) u_ack_arb (
    .clk(clk), .rst_n(rst_n), .elig(ack_elig), .rank(src_rank),
    .win_valid(hit_valid), .win_idx(hit_idx), .win_rank(hit_rank)
  );

  logic [LVL_W-1:0] fwd_lvl;
  assign fwd_lvl = fwd_valid ? fwd_rank[RANK_W-1:SLOT_W] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_level <= '0;
    else        irq_level <= fwd_lvl;
  end

  lpic_ack_unit #(.NSRC(NSRC), .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)) u_ack (
    .clk(clk), .rst_n(rst_n), .iack_valid(iack_valid), .iack_level(iack_level),
    .hit_valid(hit_valid), .hit_idx(hit_idx),
    .ack_done(ack_done), .ack_vector(ack_vector), .ack_level(ack_level)
  );

  // R6: a presented level is above the core mask, or is the top level
  a_r6_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_level == TOP_LVL || irq_level > $past(cpu_mask)));
  // R8: the acknowledge winner sits on the acknowledged level
  a_r8_hit_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_valid && hit_valid) |-> (hit_rank[RANK_W-1:SLOT_W] == iack_level));
  // R10: an acknowledge alone does not change the presented level
  a_r10_ack_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_valid && $stable(irq_req) && $stable(cpu_mask) && !wr_en &&
     $past(!wr_en) && $past(iack_valid)) |=> $stable(irq_level));
endmodule

// File: tb/tb_lpic_top.sv
module tb_lpic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic [2:0]  cpu_mask = '0;
  logic        wr_en = 1'b0;
  logic        wr_mask = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [5:0]  wr_data = '0;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [2:0]  irq_level;
  logic        ack_done;
  logic [7:0]  ack_vector;
  logic [2:0]  ack_level;

  always #2 clk = ~clk;

  lpic_top dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpu_mask(cpu_mask),
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(wr_addr), .wr_data(wr_data),
    .iack_valid(iack_valid), .iack_level(iack_level),
    .irq_level(irq_level), .ack_done(ack_done), .ack_vector(ack_vector),
    .ack_level(ack_level)
  );

  int applied = 0;
  int failed  = 0;
  bit finished = 1'b0;

  // Bench model: a priority is scored at twice its value; the mid-point scores 7.
  int m_lvl [64];
  int m_pri [64];
  bit m_msk [64];

  typedef struct { int vec; int lvl; string tag; } exp_t;
  exp_t sb[$];

  function automatic int score(int i);
    return (m_pri[i] < 0) ? 7 : 2 * m_pri[i];
  endfunction

  function automatic bit pend(int i);
    return (i > 0) && irq_req[i] && !m_msk[i] && (m_lvl[i] != 0);
  endfunction

  function automatic int model_level();
    int best = 0;
    for (int i = 1; i < 64; i++)
      if (pend(i) && (m_lvl[i] > int'(cpu_mask) || m_lvl[i] == 7) && m_lvl[i] > best)
        best = m_lvl[i];
    return best;
  endfunction

  function automatic int model_vec(int l);
    int who = -1;
    int bs = -1;
    for (int i = 1; i < 64; i++)
      if (pend(i) && m_lvl[i] == l && score(i) > bs) begin
        bs = score(i);
        who = i;
      end
    return (who < 0) ? 24 : 64 + who;
  endfunction

  task automatic check(string tag, int act, int exp);
    applied++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(int a, int l, int p);
    @(negedge clk);
    wr_en = 1'b1; wr_mask = 1'b0; wr_addr = 6'(a); wr_data = {3'(l), 3'(p)};
    if (a >= 8) begin m_lvl[a] = l; m_pri[a] = p; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_msk(int a, bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_mask = 1'b1; wr_addr = 6'(a); wr_data = {5'd0, v};
    if (a > 0) m_msk[a] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_level(string tag);
    settle();
    check(tag, int'(irq_level), model_level());
  endtask

  task automatic do_ack(int l, string tag);
    exp_t e;
    @(negedge clk);
    e.vec = model_vec(l); e.lvl = l; e.tag = tag;
    sb.push_back(e);
    iack_valid = 1'b1; iack_level = 3'(l);
    @(negedge clk);
    iack_valid = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per acknowledge response.
  always @(negedge clk) begin
    if (rst_n && ack_done) begin
      if (sb.size() == 0) begin
        check("R8 unexpected ack_done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " vector"}, int'(ack_vector), e.vec);
        check("R8 ack_level echo", int'(ack_level), e.lvl);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failed++;
      applied++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_lvl[i] = (i < 8) ? i : 0;
      m_pri[i] = (i < 8) ? -1 : 0;
      m_msk[i] = 1'b1;
    end
    irq_req = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1: all masked after reset, nothing forwarded
    check("R1 irq_level after reset", int'(irq_level), 0);
    check("R1 ack_done after reset", int'(ack_done), 0);
    irq_req = '0;

    // R2: wired source 5 lands on level 5
    wr_msk(5, 0);
    irq_req[5] = 1'b1;
    chk_level("R2 wired source level");
    check("R2 wired level value", int'(irq_level), 5);
    // R6: mask gating
    cpu_mask = 3'd5;
    chk_level("R6 level equal to mask blocked");
    cpu_mask = 3'd4;
    chk_level("R6 level above mask forwarded");
    wr_msk(7, 0);
    irq_req[7] = 1'b1;
    cpu_mask = 3'd7;
    chk_level("R6 level 7 passes mask 7");
    cpu_mask = 3'd0;
    chk_level("R4 higher level wins");
    irq_req[7] = 1'b0;
    irq_req[5] = 1'b0;
    settle();

    // R7: one-clock latency
    @(negedge clk);
    irq_req[5] = 1'b1;
    #1 check("R7 no combinational path", int'(irq_level), 0);
    @(negedge clk);
    check("R7 level after one clock", int'(irq_level), 5);
    irq_req[5] = 1'b0;
    settle();

    // R4: ordering inside level 3 around the mid-point
    wr_cfg(20, 3, 6);
    wr_cfg(30, 3, 2);
    wr_msk(20, 0); wr_msk(30, 0); wr_msk(3, 0);
    irq_req[20] = 1'b1; irq_req[30] = 1'b1; irq_req[3] = 1'b1;
    chk_level("R4 level 3 pending");
    do_ack(3, "R4 priority 6 beats mid-point");
    do_ack(3, "R10 repeated acknowledge");
    chk_level("R10 level kept after acknowledge");
    irq_req[20] = 1'b0;
    do_ack(3, "R4 mid-point beats priority 2");
    wr_cfg(30, 3, 4);
    do_ack(3, "R4 priority 4 beats mid-point");
    irq_req[3] = 1'b0; irq_req[30] = 1'b0;

    // R5: tie on level 2 priority 5
    wr_cfg(41, 2, 5);
    wr_cfg(40, 2, 5);
    wr_msk(41, 0); wr_msk(40, 0);
    irq_req[40] = 1'b1; irq_req[41] = 1'b1;
    do_ack(2, "R5 tie goes to lower number");
    check("R5 expected source 40", model_vec(2), 104);
    // R8: acknowledge ignores cpu_mask
    cpu_mask = 3'd7;
    do_ack(2, "R8 acknowledge under full mask");
    chk_level("R6 level 2 blocked by mask 7");
    cpu_mask = 3'd0;
    // R9: spurious
    do_ack(6, "R9 empty level");
    // R2: writes to a wired source are ignored
    wr_cfg(3, 1, 7);
    irq_req[3] = 1'b1;
    do_ack(1, "R2 wired source not moved away");
    do_ack(3, "R2 wired source still on its level");
    irq_req[3] = 1'b0;
    // R3: level 0 never requests; masking removes a source
    wr_cfg(50, 0, 7);
    wr_msk(50, 0);
    irq_req[50] = 1'b1;
    do_ack(0, "R3 level 0 acknowledge");
    wr_msk(40, 1);
    do_ack(2, "R3 masked source skipped");
    irq_req[40] = 1'b0; irq_req[41] = 1'b0;
    chk_level("R3 level 0 source not forwarded");
    check("R3 level 0 value", int'(irq_level), 0);

    repeat (3) @(negedge clk);
    if (sb.size() != 0) check("R8 responses outstanding", sb.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule